// File: doc/BRIEF.md
# Memory Response Watchdog Counter

This block guards the handshake between a controller and the message memory attached to it. Each access start loads an 8-bit down-counter with a programmed reload value. Each ready response from the memory reloads it again. While an access is outstanding the counter drops by one per clock. If it reaches zero before the memory answers, the counter stops there. A sticky timeout flag is then raised for the interrupt logic, and it holds until an explicit clear pulse.

The counter runs on the peripheral bus clock. When no access is outstanding it does not count. A reload value of zero turns the watchdog off completely. The current count is brought out as a status output.

Top module: `mem_resp_watchdog`

## Requirements
- R1: After reset `count_o` is 0, `timeout_o` is 0 and the counter is idle, so it does not decrement.
- R2: When `acc_start_i` is high and `reload_i` is nonzero, `count_o` equals `reload_i` on the next cycle and the counter becomes active.
- R3: When `mem_ready_i` is high, `acc_start_i` is low and `reload_i` is nonzero, `count_o` equals `reload_i` on the next cycle and the counter goes idle. After that it holds its value until the next start.
- R4: While active, `count_o` falls by exactly one per cycle. On the edge where it reaches 0, `timeout_o` is set and the counter halts at 0. It does not wrap.
- R5: When `reload_i` is 0, the next cycle has `count_o` equal to 0 and the counter idle. A start has no effect and no timeout is raised.
- R6: Once set, `timeout_o` stays high until a cycle with `flag_clr_i` high. It is low on the cycle after that clear.
- R7: If a timeout occurs in the same cycle as `flag_clr_i`, the set wins and `timeout_o` is high on the next cycle.
- R8: If `acc_start_i` and `mem_ready_i` are high together, the start wins. The counter loads `reload_i` and stays active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_start_i | input | 1 | Pulse marking the start of a memory access |
| mem_ready_i | input | 1 | Memory completion response |
| reload_i | input | 8 | Programmed watchdog reload value; 0 disables |
| flag_clr_i | input | 1 | Clears the timeout flag |
| count_o | output | 8 | Current counter value |
| timeout_o | output | 1 | Sticky timeout flag |

## Verification
A corrupted count or a wrong activity bit shows on `count_o` one cycle after the stimulus. It appears either as a wrong load value or as a count that keeps falling or stays stuck while it should do the other. A wrong activity bit reaches `timeout_o` no later than `reload_i` cycles after a start: the flag rises too early, too late, or without cause. The bench compares both outputs against a cycle model on every cycle, so any such divergence is reported within one cycle of becoming visible.

// File: rtl/mem_resp_watchdog.sv
module mem_resp_watchdog #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_start_i,
  input  logic          mem_ready_i,
  input  logic [CW-1:0] reload_i,
  input  logic          flag_clr_i,
  output logic [CW-1:0] count_o,
  output logic          timeout_o
);

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          flag_q;
  logic          enabled;
  logic          expire;

  assign enabled = (reload_i != '0);
  assign expire  = enabled && !acc_start_i && !mem_ready_i && busy_q && (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (!enabled) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (acc_start_i) begin
      cnt_q  <= reload_i;
      busy_q <= 1'b1;
    end else if (mem_ready_i) begin
      cnt_q  <= reload_i;
      busy_q <= 1'b0;
    end else if (busy_q && cnt_q != '0) begin
      cnt_q  <= cnt_q - CW'(1);
      busy_q <= !expire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= expire | (flag_q & ~flag_clr_i);
  end

  assign count_o   = cnt_q;
  assign timeout_o = flag_q;

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start_i && reload_i != '0) |=> (count_o == $past(reload_i))); // R2

  AST_READY_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ready_i && !acc_start_i && reload_i != '0) |=> (count_o == $past(reload_i))); // R3

  AST_ZERO_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> (count_o == '0)); // R4

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == '0 && !acc_start_i && !mem_ready_i) |=> (count_o == '0)); // R4

  AST_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_i == '0) |=> (count_o == '0)); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_o && !flag_clr_i) |=> timeout_o); // R6

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_i != '0 && !acc_start_i && !mem_ready_i && count_o != '0) |=>
      (count_o == $past(count_o) || count_o == $past(count_o) - CW'(1))); // R4

endmodule

// File: tb/test_mem_resp_watchdog.sv
module test_mem_resp_watchdog;
  logic clk = 1'b0;
  logic rst_n;
  logic acc_start_i, mem_ready_i, flag_clr_i;
  logic [7:0] reload_i;
  logic [7:0] count_o;
  logic timeout_o;

  always #10 clk = ~clk;

  mem_resp_watchdog i_mem_resp_watchdog (
    .clk(clk), .rst_n(rst_n), .acc_start_i(acc_start_i), .mem_ready_i(mem_ready_i),
    .reload_i(reload_i), .flag_clr_i(flag_clr_i), .count_o(count_o), .timeout_o(timeout_o)
  );

  int compared = 0;
  int mismatched = 0;
  logic [7:0] m_cnt;
  logic m_act, m_flag;

  function automatic logic [9:0] model_next(logic [7:0] c, logic a, logic f,
                                            logic s, logic r, logic [7:0] rl, logic clr);
    logic set = 1'b0;
    if (rl == 0) begin c = 0; a = 0; end
    else if (s) begin c = rl; a = 1; end
    else if (r) begin c = rl; a = 0; end
    else if (a && c != 0) begin
      c = c - 8'd1;
      if (c == 0) begin set = 1'b1; a = 1'b0; end
    end
    f = set | (f & ~clr);
    return {a, f, c};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m_cnt = 0; m_act = 0; m_flag = 0; end
    else {m_act, m_flag, m_cnt} = model_next(m_cnt, m_act, m_flag,
                                             acc_start_i, mem_ready_i, reload_i, flag_clr_i);
  end

  task automatic chk(string tag, logic [7:0] ec, logic ef);
    compared++;
    if (count_o !== ec || timeout_o !== ef) begin
      mismatched++;
      $display("FAIL %s: count=%0d flag=%0b expected count=%0d flag=%0b", tag, count_o, timeout_o, ec, ef);
    end
  endtask

  task automatic step(logic s, logic r, logic [7:0] rl, logic c);
    acc_start_i = s; mem_ready_i = r; reload_i = rl; flag_clr_i = c;
    @(negedge clk);
  endtask

  initial begin
    fork
      begin
        acc_start_i = 0; mem_ready_i = 0; reload_i = 8'd3; flag_clr_i = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 reset", 8'd0, 1'b0);
        step(0, 0, 3, 0); chk("R1 idle after reset", 8'd0, 1'b0);

        step(1, 0, 3, 0); chk("R2 start load", 8'd3, 1'b0);
        step(0, 0, 3, 0); chk("R4 decrement", 8'd2, 1'b0);
        step(0, 0, 3, 0); chk("R4 decrement", 8'd1, 1'b0);
        step(0, 0, 3, 0); chk("R4 expire", 8'd0, 1'b1);
        step(0, 0, 3, 0); chk("R4 halt at zero / R6 sticky", 8'd0, 1'b1);
        step(0, 0, 3, 1); chk("R6 clear", 8'd0, 1'b0);

        step(1, 0, 5, 0); chk("R2 start load 5", 8'd5, 1'b0);
        step(0, 0, 5, 0); chk("R4 decrement", 8'd4, 1'b0);
        step(0, 1, 5, 0); chk("R3 ready reload", 8'd5, 1'b0);
        step(0, 0, 5, 0); chk("R3 idle after ready", 8'd5, 1'b0);
        step(0, 0, 5, 0); chk("R3 idle holds", 8'd5, 1'b0);

        step(1, 1, 4, 0); chk("R8 start with ready", 8'd4, 1'b0);
        step(0, 0, 4, 0); chk("R8 stays active", 8'd3, 1'b0);

        step(1, 0, 2, 0); chk("R2 load 2", 8'd2, 1'b0);
        step(0, 0, 2, 1); chk("R7 set over clear", 8'd1, 1'b0);
        step(0, 0, 2, 1); chk("R7 set over clear", 8'd0, 1'b1);
        step(0, 0, 2, 1); chk("R6 clear after R7", 8'd0, 1'b0);

        step(1, 0, 1, 0); chk("R2 load 1", 8'd1, 1'b0);
        step(0, 0, 1, 0); chk("R4 reload 1 expires", 8'd0, 1'b1);
        step(0, 0, 1, 1); chk("R6 clear", 8'd0, 1'b0);

        step(1, 0, 4, 0); chk("R2 load 4", 8'd4, 1'b0);
        step(0, 0, 0, 0); chk("R5 disable forces zero", 8'd0, 1'b0);
        step(1, 0, 0, 0); chk("R5 start ignored", 8'd0, 1'b0);
        for (int k = 0; k < 4; k++) begin
          step(0, 0, 0, 0); chk("R5 no timeout while disabled", 8'd0, 1'b0);
        end
        step(0, 0, 6, 0); chk("R5 re-enable stays idle", 8'd0, 1'b0);

        void'($urandom(32'h5eed_1234));
        for (int n = 0; n < 3000; n++) begin
          logic [7:0] rl;
          rl = ($urandom % 10 == 0) ? 8'd0 : 8'($urandom % 7 + 1);
          step(($urandom % 6) == 0, ($urandom % 5) == 0, rl, ($urandom % 8) == 0);
          chk("random model", m_cnt, m_flag);
        end
      end
      begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    disable fork;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule